// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns a single asynchronous serial line into parallel characters. It runs on one clock that ticks sixteen times per bit period. It finds the falling edge of a start bit and confirms the start bit at its middle. It then takes every further bit one bit period after the previous sample. A character of five to eight data bits, sent least significant bit first, lands right-justified in a receive buffer. The buffer load happens at the middle of the first stop bit. A ready flag and three error flags (overrun, framing, parity) report on each load. The host lowers an active-low clear input to acknowledge a character. An active-high master reset clears the flags.

The frame engine has five named states. IDLE waits for an edge. START confirms the start bit. DATA shifts in the data bits. PARITY takes the parity bit. STOP takes the first stop bit. The transitions are:
- IDLE to START on a synchronised falling edge.
- START to IDLE if the start bit reads high at its middle (noise).
- START to DATA if the start bit is still low at its middle.
- DATA to DATA after each data bit that is not the last.
- DATA to PARITY after the last data bit when parity is enabled.
- DATA to STOP after the last data bit when parity is disabled.
- PARITY to STOP after the parity bit.
- STOP to IDLE at the middle of the first stop bit, together with the buffer load.

The format inputs (length, parity enable, parity sense) are captured when a start edge is detected.

Top module: `serial_rx16`

## Requirements
- R1: The line idles high. A high-to-low change, passed through a two-flop synchroniser, starts a frame. The start bit is re-sampled 8 clocks after the edge is detected, and each later bit is sampled 16 clocks after the sample before it.
- R2: A start bit that reads high at its middle sample is dropped as noise. The receiver returns to IDLE, and no flag or buffer bit changes.
- R3: Data bits arrive least significant bit first. They are stored right-justified in `rx_data`, and buffer bits above the programmed length read 0.
- R4: `len_sel` picks the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7, 11 gives 8.
- R5: With `par_off` = 0, one parity bit follows the data. `par_even` = 1 selects even parity and 0 selects odd. A mismatch sets `err_parity` at the buffer load, and a match clears it.
- R6: With `par_off` = 1, no parity bit is expected and `err_parity` stays 0.
- R7: At each buffer load, `err_overrun` takes the value of `rx_ready` just before that load. It is 1 when the previous character was not cleared.
- R8: The buffer load happens at the middle sample of the first stop bit. Count the posedge that first samples a low line as P0, and number the bits from 0 at the start bit. If the stop bit has index s, `rx_data` changes at posedge P(10+16s). `rx_ready` rises exactly one clock later.
- R9: `err_frame` is updated in the same clock as `rx_ready` rises. It is 1 when the first stop bit was sampled low and 0 otherwise.
- R10: `dr_clr_n` = 0 clears `rx_ready` on the next edge. A ready set in that same clock takes priority.
- R11: The search for the next start edge resumes one clock after the middle of the first stop bit. A following frame whose start edge comes 12 clocks into the stop bit is received.
- R12: `mreset` = 1 clears `rx_ready`, `err_overrun`, `err_frame` and `err_parity`, and leaves `rx_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16 times the bit rate |
| mreset | input | 1 | Master reset, active high |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| len_sel | input | 2 | Character length code (5 to 8 bits) |
| par_off | input | 1 | 1 disables the parity bit and parity checking |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| dr_clr_n | input | 1 | Active-low clear of the ready flag |
| rx_data | output | 8 | Receive buffer, right-justified character |
| rx_ready | output | 1 | A character has been loaded and not yet cleared |
| err_overrun | output | 1 | Last load overwrote an uncleared character |
| err_frame | output | 1 | First stop bit of the last character was low |
| err_parity | output | 1 | Parity of the last character did not match |

## Verification
A wrong oversampling count shows up as a shifted bit. The bench captures the exact cycle at which `rx_data` changes after the start edge, so a one-clock slip in the centre count appears at the first load. A counter that drifts between bits instead corrupts the high data bits or flags a framing error within one character.

A bit index stuck one step off shows up the same way. A flag order reversed between load and ready is caught by the one-clock gap check. A noise start bit that leaves the engine out of IDLE corrupts the very next valid frame.

// File: rtl/serial_rx16_pkg.sv
package serial_rx16_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [1:0] len;
        logic       par_off;
        logic       par_even;
    } rx_cfg_t;

endpackage

// File: rtl/serial_rx16_sync.sv
module serial_rx16_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic mreset,
    input  logic din,
    output logic rx_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (mreset) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign rx_s = chain[STAGES-1];
    assign fall = prev & ~rx_s;

endmodule

// File: rtl/serial_rx16_fsm.sv
module serial_rx16_fsm
    import serial_rx16_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int DMAX = 8
) (
    input  logic            clk,
    input  logic            mreset,
    input  logic            rx_s,
    input  logic            fall,
    input  rx_cfg_t         cfg_in,
    output logic            xfer,
    output logic [DMAX-1:0] word,
    output logic            par_bad,
    output logic            stop_ok,
    output rx_cfg_t         cfg_q
);
    localparam int CW   = $clog2(OSR);
    localparam int BW   = $clog2(DMAX);
    localparam int MINB = DMAX - 3;
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_t       state_q, state_d;
    logic [CW-1:0]   cnt;
    logic [BW-1:0]   bit_idx;
    logic [BW-1:0]   last_idx;
    logic [DMAX-1:0] shreg;
    logic            par_acc;
    logic            centre;

    assign last_idx = BW'(MINB - 1) + BW'(cfg_q.len);
    assign centre   = (state_q == ST_START) ? (cnt == MID) : (cnt == LAST);

    // state register
    always_ff @(posedge clk) begin
        if (mreset) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (fall) state_d = ST_START;
            ST_START:  if (centre) state_d = rx_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (centre && bit_idx == last_idx)
                           state_d = cfg_q.par_off ? ST_STOP : ST_PARITY;
            ST_PARITY: if (centre) state_d = ST_STOP;
            ST_STOP:   if (centre) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath: oversample counter, bit index, shifter, parity accumulator
    always_ff @(posedge clk) begin
        if (mreset) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            cfg_q   <= '0;
        end else begin
            if (state_q == ST_IDLE || centre) cnt <= '0;
            else                              cnt <= cnt + 1'b1;

            if (state_q == ST_IDLE && fall) begin
                cfg_q   <= cfg_in;
                bit_idx <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
            end
            if (state_q == ST_DATA && centre) begin
                shreg   <= {rx_s, shreg[DMAX-1:1]};
                par_acc <= par_acc ^ rx_s;
                bit_idx <= bit_idx + 1'b1;
            end
            if (state_q == ST_PARITY && centre) par_acc <= par_acc ^ rx_s;
        end
    end

    // outputs
    always_comb begin
        xfer    = (state_q == ST_STOP) && centre;
        word    = shreg >> (DMAX - 1 - int'(last_idx));
        stop_ok = rx_s;
        if (cfg_q.par_off) par_bad = 1'b0;
        else               par_bad = cfg_q.par_even ? par_acc : ~par_acc;
    end

    // R2: a start bit high at its middle returns the engine to idle
    a_r2_noise_to_idle: assert property (@(posedge clk) disable iff (mreset)
        (state_q == ST_START && cnt == MID && rx_s) |=> (state_q == ST_IDLE));

    // R1: idle is left only on a detected falling edge
    a_r1_idle_waits_edge: assert property (@(posedge clk) disable iff (mreset)
        (state_q == ST_IDLE && !fall) |=> (state_q == ST_IDLE));

    // R11: the stop-bit middle hands control back to idle
    a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (mreset)
        xfer |=> (state_q == ST_IDLE));

endmodule

// File: rtl/serial_rx16_flags.sv
module serial_rx16_flags
    import serial_rx16_pkg::*;
#(
    parameter int DMAX = 8
) (
    input  logic            clk,
    input  logic            mreset,
    input  logic            xfer,
    input  logic [DMAX-1:0] word,
    input  logic            par_bad,
    input  logic            stop_ok,
    input  rx_cfg_t         cfg_q,
    input  logic            dr_clr_n,
    output logic [DMAX-1:0] rx_data,
    output logic            rx_ready,
    output logic            err_overrun,
    output logic            err_frame,
    output logic            err_parity
);
    localparam int MINB = DMAX - 3;

    logic xfer_d;
    logic stop_q;
    int   nbits;

    assign nbits = MINB + int'(cfg_q.len);

    // receive buffer: never touched by master reset
    always_ff @(posedge clk) begin
        if (!mreset && xfer) rx_data <= word;
    end

    always_ff @(posedge clk) begin
        if (mreset) begin
            xfer_d      <= 1'b0;
            stop_q      <= 1'b1;
            rx_ready    <= 1'b0;
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
        end else begin
            xfer_d <= xfer;
            if (xfer) begin
                err_overrun <= rx_ready;
                err_parity  <= par_bad;
                stop_q      <= stop_ok;
            end
            if (xfer_d) begin
                rx_ready  <= 1'b1;
                err_frame <= ~stop_q;
            end else if (!dr_clr_n) begin
                rx_ready <= 1'b0;
            end
        end
    end

    a_r7_overrun_on_uncleared: assert property (@(posedge clk) disable iff (mreset)
        (xfer && rx_ready) |=> err_overrun);

    a_r8_ready_after_load: assert property (@(posedge clk) disable iff (mreset)
        xfer |=> ##1 rx_ready);

    a_r9_frame_from_stop: assert property (@(posedge clk) disable iff (mreset)
        (xfer && !stop_ok) |=> ##1 err_frame);

    a_r10_clear_ready: assert property (@(posedge clk) disable iff (mreset)
        (!dr_clr_n && !xfer_d) |=> !rx_ready);

    a_r6_parity_off_low: assert property (@(posedge clk) disable iff (mreset)
        (xfer && cfg_q.par_off) |=> !err_parity);

    a_r3_high_bits_zero: assert property (@(posedge clk) disable iff (mreset)
        xfer |=> ((rx_data >> nbits) == '0));

    a_r12_reset_clears: assert property (@(posedge clk)
        mreset |=> (!rx_ready && !err_overrun && !err_frame && !err_parity));

endmodule

// File: rtl/serial_rx16.sv
module serial_rx16
    import serial_rx16_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int DMAX    = 8,
    parameter int SYNC_ST = 2
) (
    input  logic            clk,
    input  logic            mreset,
    input  logic            rx_in,
    input  logic [1:0]      len_sel,
    input  logic            par_off,
    input  logic            par_even,
    input  logic            dr_clr_n,
    output logic [DMAX-1:0] rx_data,
    output logic            rx_ready,
    output logic            err_overrun,
    output logic            err_frame,
    output logic            err_parity
);
    logic            rx_s;
    logic            fall;
    logic            xfer;
    logic [DMAX-1:0] word;
    logic            par_bad;
    logic            stop_ok;
    rx_cfg_t         cfg_in;
    rx_cfg_t         cfg_q;

    assign cfg_in = '{len: len_sel, par_off: par_off, par_even: par_even};

    serial_rx16_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk    (clk),
        .mreset (mreset),
        .din    (rx_in),
        .rx_s   (rx_s),
        .fall   (fall)
    );

    serial_rx16_fsm #(.OSR(OSR), .DMAX(DMAX)) u_fsm (
        .clk     (clk),
        .mreset  (mreset),
        .rx_s    (rx_s),
        .fall    (fall),
        .cfg_in  (cfg_in),
        .xfer    (xfer),
        .word    (word),
        .par_bad (par_bad),
        .stop_ok (stop_ok),
        .cfg_q   (cfg_q)
    );

    serial_rx16_flags #(.DMAX(DMAX)) u_flags (
        .clk         (clk),
        .mreset      (mreset),
        .xfer        (xfer),
        .word        (word),
        .par_bad     (par_bad),
        .stop_ok     (stop_ok),
        .cfg_q       (cfg_q),
        .dr_clr_n    (dr_clr_n),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .err_overrun (err_overrun),
        .err_frame   (err_frame),
        .err_parity  (err_parity)
    );

endmodule

// File: tb/serial_rx16_test.sv
module serial_rx16_test;
    logic       clk = 1'b0;
    logic       mreset;
    logic       rx_in;
    logic [1:0] len_sel;
    logic       par_off;
    logic       par_even;
    logic       dr_clr_n;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       err_overrun;
    logic       err_frame;
    logic       err_parity;

    int cyc = 0;
    int t_start = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_rx16 uut (
        .clk(clk), .mreset(mreset), .rx_in(rx_in), .len_sel(len_sel),
        .par_off(par_off), .par_even(par_even), .dr_clr_n(dr_clr_n),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_overrun(err_overrun),
        .err_frame(err_frame), .err_parity(err_parity)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input int rdy, input int oe, input int fe, input int pe);
        chk(req, "rx_ready", int'(rx_ready), rdy);
        chk(req, "err_overrun", int'(err_overrun), oe);
        chk(req, "err_frame", int'(err_frame), fe);
        chk(req, "err_parity", int'(err_parity), pe);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic poff, input logic pev);
        len_sel = l; par_off = poff; par_even = pev;
    endtask

    task automatic clear_ready();
        dr_clr_n = 1'b0;
        wait_clk(1);
        dr_clr_n = 1'b1;
        wait_clk(1);
    endtask

    // pm: 0 none, 1 even, 2 odd
    task automatic send_frame(input logic [7:0] d, input int nb, input int pm,
                              input bit flip, input bit stopv, input int stoplen);
        logic [7:0] m;
        logic p;
        m = 8'((9'h1 << nb) - 9'h1);
        p = ^(d & m);
        if (pm == 2) p = ~p;
        if (flip) p = ~p;
        t_start = cyc;
        rx_in = 1'b0;
        wait_clk(16);
        for (int i = 0; i < nb; i++) begin
            rx_in = d[i];
            wait_clk(16);
        end
        if (pm != 0) begin
            rx_in = p;
            wait_clk(16);
        end
        rx_in = stopv;
        wait_clk(stoplen);
        rx_in = 1'b1;
    endtask

    task automatic t_reset();
        chk_flags("R12", 0, 0, 0, 0);
    endtask

    task automatic t_basic();
        set_cfg(2'b11, 1'b1, 1'b0);
        send_frame(8'hA5, 8, 0, 0, 1, 16); wait_clk(8);
        chk("R1", "rx_data 8N1", int'(rx_data), 'hA5);
        chk_flags("R1", 1, 0, 0, 0);
        clear_ready();
        send_frame(8'h3C, 8, 0, 0, 1, 16); wait_clk(8);
        chk("R3", "rx_data lsb first", int'(rx_data), 'h3C);
        clear_ready();
    endtask

    task automatic t_lengths();
        set_cfg(2'b11, 1'b1, 1'b0);
        send_frame(8'hFF, 8, 0, 0, 1, 16); wait_clk(8); clear_ready();
        set_cfg(2'b00, 1'b1, 1'b0);
        send_frame(8'hF5, 5, 0, 0, 1, 16); wait_clk(8);
        chk("R4", "5-bit, high bits zero (R3)", int'(rx_data), 'h15);
        clear_ready();
        set_cfg(2'b01, 1'b1, 1'b0);
        send_frame(8'h2B, 6, 0, 0, 1, 16); wait_clk(8);
        chk("R4", "6-bit", int'(rx_data), 'h2B);
        clear_ready();
        set_cfg(2'b10, 1'b1, 1'b0);
        send_frame(8'h5A, 7, 0, 0, 1, 16); wait_clk(8);
        chk("R4", "7-bit", int'(rx_data), 'h5A);
        clear_ready();
    endtask

    task automatic t_parity();
        set_cfg(2'b11, 1'b0, 1'b1);
        send_frame(8'h71, 8, 1, 0, 1, 16); wait_clk(8);
        chk("R5", "even good data", int'(rx_data), 'h71);
        chk("R5", "even good pe", int'(err_parity), 0);
        clear_ready();
        send_frame(8'h71, 8, 1, 1, 1, 16); wait_clk(8);
        chk("R5", "even bad pe", int'(err_parity), 1);
        clear_ready();
        set_cfg(2'b10, 1'b0, 1'b0);
        send_frame(8'h13, 7, 2, 0, 1, 16); wait_clk(8);
        chk("R5", "odd good pe", int'(err_parity), 0);
        clear_ready();
        send_frame(8'h13, 7, 2, 1, 1, 16); wait_clk(8);
        chk("R5", "odd bad pe", int'(err_parity), 1);
        clear_ready();
    endtask

    task automatic t_no_parity();
        set_cfg(2'b10, 1'b1, 1'b1);
        send_frame(8'h4E, 7, 0, 0, 1, 16); wait_clk(8);
        chk("R6", "no parity data", int'(rx_data), 'h4E);
        chk("R6", "no parity pe low", int'(err_parity), 0);
        clear_ready();
    endtask

    task automatic t_overrun();
        set_cfg(2'b11, 1'b1, 1'b0);
        send_frame(8'h11, 8, 0, 0, 1, 16); wait_clk(8);
        chk("R7", "first no overrun", int'(err_overrun), 0);
        send_frame(8'h22, 8, 0, 0, 1, 16); wait_clk(8);
        chk("R7", "uncleared overrun", int'(err_overrun), 1);
        chk("R7", "data replaced", int'(rx_data), 'h22);
        clear_ready();
        send_frame(8'h33, 8, 0, 0, 1, 16); wait_clk(8);
        chk("R7", "cleared no overrun", int'(err_overrun), 0);
        clear_ready();
    endtask

    task automatic t_clear();
        set_cfg(2'b11, 1'b1, 1'b0);
        send_frame(8'h6D, 8, 0, 0, 1, 16); wait_clk(8);
        chk("R10", "ready before clear", int'(rx_ready), 1);
        dr_clr_n = 1'b0;
        wait_clk(1);
        chk("R10", "ready after clear", int'(rx_ready), 0);
        dr_clr_n = 1'b1;
        wait_clk(1);
    endtask

    task automatic t_framing();
        set_cfg(2'b11, 1'b1, 1'b0);
        send_frame(8'h81, 8, 0, 0, 0, 16); wait_clk(20);
        chk("R9", "low stop sets fe", int'(err_frame), 1);
        chk("R9", "data still loaded", int'(rx_data), 'h81);
        clear_ready();
        send_frame(8'h82, 8, 0, 0, 1, 16); wait_clk(8);
        chk("R9", "good stop clears fe", int'(err_frame), 0);
        clear_ready();
    endtask

    task automatic t_noise();
        set_cfg(2'b11, 1'b1, 1'b0);
        rx_in = 1'b0; wait_clk(4);
        rx_in = 1'b1; wait_clk(60);
        chk("R2", "noise no ready", int'(rx_ready), 0);
        chk("R2", "noise buffer kept", int'(rx_data), 'h82);
        send_frame(8'h9E, 8, 0, 0, 1, 16); wait_clk(8);
        chk("R2", "frame after noise", int'(rx_data), 'h9E);
        clear_ready();
    endtask

    task automatic t_timing();
        int dcyc;
        int rcyc;
        dcyc = -1;
        rcyc = -1;
        set_cfg(2'b11, 1'b1, 1'b0);
        fork
            send_frame(8'h5C, 8, 0, 0, 1, 16);
            begin
                for (int k = 0; k < 200; k++) begin
                    @(negedge clk);
                    if (dcyc < 0 && rx_data == 8'h5C) dcyc = cyc;
                    if (rcyc < 0 && rx_ready) rcyc = cyc;
                end
            end
        join
        // stop bit index 9 for 8N1
        chk("R8", "load cycle", dcyc - t_start, 11 + 16 * 9);
        chk("R8", "ready one clock later", rcyc - dcyc, 1);
        clear_ready();
    endtask

    task automatic t_back2back();
        set_cfg(2'b11, 1'b1, 1'b0);
        send_frame(8'hC3, 8, 0, 0, 1, 12);
        chk("R11", "first of pair", int'(rx_data), 'hC3);
        send_frame(8'h3E, 8, 0, 0, 1, 16); wait_clk(8);
        chk("R11", "second of pair", int'(rx_data), 'h3E);
        chk("R11", "second no framing", int'(err_frame), 0);
        clear_ready();
    endtask

    task automatic t_master_reset();
        set_cfg(2'b11, 1'b0, 1'b1);
        send_frame(8'hE7, 8, 1, 0, 1, 16); wait_clk(8);
        send_frame(8'hD4, 8, 1, 1, 0, 16); wait_clk(20);
        chk_flags("R12", 1, 1, 1, 1);
        mreset = 1'b1;
        wait_clk(2);
        mreset = 1'b0;
        wait_clk(1);
        chk_flags("R12", 0, 0, 0, 0);
        chk("R12", "buffer kept", int'(rx_data), 'hD4);
    endtask

    initial begin
        mreset = 1'b1; rx_in = 1'b1; dr_clr_n = 1'b1;
        set_cfg(2'b11, 1'b1, 1'b0);
        wait_clk(4);
        mreset = 1'b0;
        wait_clk(4);
        t_reset();
        t_basic();
        t_lengths();
        t_parity();
        t_no_parity();
        t_overrun();
        t_clear();
        t_framing();
        t_noise();
        t_timing();
        t_back2back();
        t_master_reset();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule